// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a set of maskable sources, one non-maskable input and two exception inputs (hardware fault and software trap), and picks a single winner for the processor core. Every source owns a sticky request flag, so a one-cycle request pulse waits until it is served. A writable mask word, a global enable flag and an instruction-boundary strobe from the core decide when a request may be taken. The maskable sources are split into two classes by a parameter: block-transfer (DMA-class) sources rank above ordinary device sources.

When a request is accepted the block runs a fixed three-cycle sequence. First it pulses an acknowledge, with the global enable already cleared. Then it asks the core to save its breakpoint and says whether the current or the next instruction address is the right one. Finally it presents the type number of the source and the handler entry address, computed as a programmable table base plus four times the type number. The core writes the mask, the enable and the table base through a small register-write port.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset no acknowledge, save or vector pulse is present, the global enable (`int_en_o`) is 0, every mask bit is 1 (all maskable sources blocked) and the table base is 0.
- R2: A request pulse on `irq_i[i]` of any length sets a flag that stays set until that source is accepted; one acceptance clears it, so one pulse gives one acceptance.
- R3: A mask bit of 1 blocks maskable source i, a mask bit of 0 lets it through; a blocked request stays pending and is taken once its mask bit is cleared.
- R4: Maskable requests are not taken while the global enable is 0; NMI and exceptions are taken whatever the enable holds.
- R5: Maskable and NMI requests are taken only on a clock edge where `boundary_i` is 1; exceptions are taken on any edge where the block is idle.
- R6: When several classes are pending and eligible on the same edge, NMI wins over hardware fault, hardware fault over software trap, and software trap over any maskable source.
- R7: Among eligible maskable sources a DMA-class source (bit set in parameter `DMA_SRCS`, default sources 6 and 7) wins over a device source; within a class the lower source index wins.
- R8: An acceptance on edge T gives `ack_o` for the cycle after T with `int_en_o` already 0, `save_o` in the next cycle and `vec_valid_o` in the one after; an enable write on edge T loses against the clearing.
- R9: During `save_o`, `bp_cur_o` is 1 for a hardware fault or software trap (resume at the current instruction) and 0 for NMI or a maskable source (resume at the next instruction).
- R10: Type numbers are 0 for hardware fault, 1 for software trap, 2 for NMI and 32+i for maskable source i; during `vec_valid_o`, `type_o` holds the type and `vec_addr_o` equals table base + 4 x type.
- R11: The NMI input is edge-sensitive: one rising edge gives exactly one acceptance, however long the input stays high.
- R12: With `cfg_we_i` high, `cfg_sel_i` = 0 writes the mask word from the low bits of `cfg_wdata_i`, 1 writes the global enable from bit 0, and 2 writes the table base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | Maskable request pulses, one per source |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| hw_fault_i | input | 1 | Hardware fault exception request |
| sw_trap_i | input | 1 | Software trap exception request |
| boundary_i | input | 1 | High in the last cycle of an instruction's execute phase |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 mask, 1 enable, 2 table base |
| cfg_wdata_i | input | 32 | Register write data |
| int_en_o | output | 1 | Current global enable flag |
| ack_o | output | 1 | One-cycle acknowledge of an accepted request |
| save_o | output | 1 | One-cycle request to save the breakpoint |
| bp_cur_o | output | 1 | Breakpoint select, valid with save_o: 1 current, 0 next instruction |
| vec_valid_o | output | 1 | One-cycle strobe for type and vector |
| vec_addr_o | output | 32 | Handler entry address |
| type_o | output | 8 | Type number of the accepted source |

## Verification
The interesting collisions are an NMI rising edge, a hardware fault and an eligible maskable flag all being ready on the same boundary edge, and a write of the global enable landing on the very edge that accepts a request. The first is provoked by setting the maskable flag early and then raising the NMI and fault inputs together one cycle before the strobe; the bench expects type 2, then type 0 without any strobe, and the maskable source only after the enable is written again. The second is judged by reading `int_en_o` in the acknowledge cycle, which must be 0 although the same edge carried a write of 1.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

  localparam int TYPE_W = 8;
  typedef logic [TYPE_W-1:0] type_t;

  // Fixed type numbers of the non-maskable classes
  localparam type_t TYPE_HWF = type_t'(0);
  localparam type_t TYPE_SWT = type_t'(1);
  localparam type_t TYPE_NMI = type_t'(2);

  typedef enum logic [1:0] {
    K_NMI = 2'd0,
    K_HWF = 2'd1,
    K_SWT = 2'd2,
    K_IRQ = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ACK  = 2'd1,
    S_SAVE = 2'd2,
    S_VEC  = 2'd3
  } seq_e;

  // Exceptions resume at the faulting instruction
  function automatic logic resume_current(kind_e k);
    return (k == K_HWF) || (k == K_SWT);
  endfunction

  // Type number of maskable source idx
  function automatic type_t src_type(int unsigned type_base, int unsigned idx);
    return type_t'(type_base + idx);
  endfunction

endpackage

// File: rtl/pvic_flags.sv
module pvic_flags #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               nmi_i,
  input  logic               hwf_i,
  input  logic               swt_i,
  input  logic [NUM_SRC-1:0] clr_irq,
  input  logic               clr_nmi,
  input  logic               clr_hwf,
  input  logic               clr_swt,
  output logic [NUM_SRC-1:0] irq_pend,
  output logic               nmi_pend,
  output logic               hwf_pend,
  output logic               swt_pend
);

  logic nmi_q;
  logic nmi_rise;

  assign nmi_rise = nmi_i && !nmi_q;

  // One sticky flag per maskable source; a new request wins over a clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) irq_pend[g] <= 1'b0;
      else        irq_pend[g] <= (irq_pend[g] && !clr_irq[g]) || irq_i[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
      hwf_pend <= 1'b0;
      swt_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_i;
      nmi_pend <= (nmi_pend && !clr_nmi) || nmi_rise;
      hwf_pend <= (hwf_pend && !clr_hwf) || hwf_i;
      swt_pend <= (swt_pend && !clr_swt) || swt_i;
    end
  end

  // R11
  nmi_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_nmi && nmi_i && nmi_q) |=> !nmi_pend);

  // R2
  hwf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hwf && !hwf_i) |=> !hwf_pend);

endmodule

// File: rtl/pvic_arb.sv
module pvic_arb
  import pvic_pkg::*;
#(
  parameter int                 NUM_SRC       = 8,
  parameter logic [NUM_SRC-1:0] DMA_SRCS      = 8'hC0,
  parameter int                 IRQ_TYPE_BASE = 32
) (
  input  logic [NUM_SRC-1:0] irq_pend,
  input  logic [NUM_SRC-1:0] mask,
  input  logic               gie,
  input  logic               boundary,
  input  logic               nmi_pend,
  input  logic               hwf_pend,
  input  logic               swt_pend,
  input  logic               idle,
  output logic               take,
  output kind_e              win_kind,
  output type_t              win_type,
  output logic [NUM_SRC-1:0] win_onehot
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] elig;
  logic               dma_hit, dev_hit, irq_ok, any_req;
  logic [IDX_W-1:0]   dma_idx, dev_idx, sel_idx;

  assign elig = irq_pend & ~mask;

  // Scan downwards so the lowest index in each class is the last to stick
  always_comb begin
    dma_hit = 1'b0;
    dev_hit = 1'b0;
    dma_idx = '0;
    dev_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i] && DMA_SRCS[i]) begin
        dma_hit = 1'b1;
        dma_idx = IDX_W'(i);
      end
      if (elig[i] && !DMA_SRCS[i]) begin
        dev_hit = 1'b1;
        dev_idx = IDX_W'(i);
      end
    end
  end

  assign sel_idx = dma_hit ? dma_idx : dev_idx;
  assign irq_ok  = gie && boundary && (dma_hit || dev_hit);

  always_comb begin
    win_kind = K_IRQ;
    win_type = src_type(IRQ_TYPE_BASE, 32'(sel_idx));
    any_req  = 1'b1;
    if (nmi_pend && boundary) begin
      win_kind = K_NMI;
      win_type = TYPE_NMI;
    end else if (hwf_pend) begin
      win_kind = K_HWF;
      win_type = TYPE_HWF;
    end else if (swt_pend) begin
      win_kind = K_SWT;
      win_type = TYPE_SWT;
    end else if (!irq_ok) begin
      any_req = 1'b0;
    end
  end

  assign take       = idle && any_req;
  assign win_onehot = (take && win_kind == K_IRQ) ? (NUM_SRC'(1) << sel_idx) : '0;

endmodule

// File: rtl/pvic_regs.sv
module pvic_regs #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  input  logic               take,
  output logic [NUM_SRC-1:0] mask_q,
  output logic               gie_q,
  output logic [ADDR_W-1:0]  base_q
);

  localparam logic [1:0] SEL_MASK = 2'd0;
  localparam logic [1:0] SEL_EN   = 2'd1;
  localparam logic [1:0] SEL_BASE = 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      gie_q  <= 1'b0;
      base_q <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          SEL_MASK: mask_q <= cfg_wdata[NUM_SRC-1:0];
          SEL_EN:   gie_q  <= cfg_wdata[0];
          SEL_BASE: base_q <= cfg_wdata;
          default:  ;
        endcase
      end
      // Acceptance clears the enable after any write on the same edge
      if (take) gie_q <= 1'b0;
    end
  end

  // R8
  take_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie_q);

endmodule

// File: rtl/pvic_seq.sv
module pvic_seq
  import pvic_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  kind_e             win_kind,
  input  type_t             win_type,
  input  logic [ADDR_W-1:0] base,
  output logic              idle,
  output kind_e             cur_kind,
  output logic              ack_o,
  output logic              save_o,
  output logic              bp_cur_o,
  output logic              vec_valid_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output type_t             type_o
);

  seq_e  state;
  type_t cur_type;

  function automatic logic [ADDR_W-1:0] entry_addr(logic [ADDR_W-1:0] b, type_t t);
    return b + (ADDR_W'(t) << 2);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_kind <= K_IRQ;
      cur_type <= '0;
    end else begin
      case (state)
        S_IDLE: if (take) begin
          state    <= S_ACK;
          cur_kind <= win_kind;
          cur_type <= win_type;
        end
        S_ACK:   state <= S_SAVE;
        S_SAVE:  state <= S_VEC;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign idle        = (state == S_IDLE);
  assign ack_o       = (state == S_ACK);
  assign save_o      = (state == S_SAVE);
  assign vec_valid_o = (state == S_VEC);
  assign bp_cur_o    = save_o && resume_current(cur_kind);
  assign type_o      = cur_type;
  assign vec_addr_o  = entry_addr(base, cur_type);

  // R8
  ack_then_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> save_o);

  // R8
  save_then_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_o |=> vec_valid_o);

  // R8
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_o, save_o, vec_valid_o}));

  // R10
  type_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_o || vec_valid_o) |-> $stable(type_o));

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvic_pkg::*;
#(
  parameter int                 NUM_SRC       = 8,
  parameter logic [NUM_SRC-1:0] DMA_SRCS      = 8'hC0,
  parameter int                 IRQ_TYPE_BASE = 32,
  parameter int                 ADDR_W        = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               nmi_i,
  input  logic               hw_fault_i,
  input  logic               sw_trap_i,
  input  logic               boundary_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [ADDR_W-1:0]  cfg_wdata_i,
  output logic               int_en_o,
  output logic               ack_o,
  output logic               save_o,
  output logic               bp_cur_o,
  output logic               vec_valid_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic [TYPE_W-1:0]  type_o
);

  logic [NUM_SRC-1:0] irq_pend, mask_q, win_onehot;
  logic               nmi_pend, hwf_pend, swt_pend;
  logic               gie_q, take, idle;
  logic [ADDR_W-1:0]  base_q;
  kind_e              win_kind, cur_kind;
  type_t              win_type, cur_type;

  // Named acceptance events per class
  logic take_nmi, take_hwf, take_swt;
  assign take_nmi = take && (win_kind == K_NMI);
  assign take_hwf = take && (win_kind == K_HWF);
  assign take_swt = take && (win_kind == K_SWT);

  pvic_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_i    (irq_i),
    .nmi_i    (nmi_i),
    .hwf_i    (hw_fault_i),
    .swt_i    (sw_trap_i),
    .clr_irq  (win_onehot),
    .clr_nmi  (take_nmi),
    .clr_hwf  (take_hwf),
    .clr_swt  (take_swt),
    .irq_pend (irq_pend),
    .nmi_pend (nmi_pend),
    .hwf_pend (hwf_pend),
    .swt_pend (swt_pend)
  );

  pvic_arb #(
    .NUM_SRC      (NUM_SRC),
    .DMA_SRCS     (DMA_SRCS),
    .IRQ_TYPE_BASE(IRQ_TYPE_BASE)
  ) u_arb (
    .irq_pend  (irq_pend),
    .mask      (mask_q),
    .gie       (gie_q),
    .boundary  (boundary_i),
    .nmi_pend  (nmi_pend),
    .hwf_pend  (hwf_pend),
    .swt_pend  (swt_pend),
    .idle      (idle),
    .take      (take),
    .win_kind  (win_kind),
    .win_type  (win_type),
    .win_onehot(win_onehot)
  );

  pvic_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we_i),
    .cfg_sel  (cfg_sel_i),
    .cfg_wdata(cfg_wdata_i),
    .take     (take),
    .mask_q   (mask_q),
    .gie_q    (gie_q),
    .base_q   (base_q)
  );

  pvic_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .win_kind   (win_kind),
    .win_type   (win_type),
    .base       (base_q),
    .idle       (idle),
    .cur_kind   (cur_kind),
    .ack_o      (ack_o),
    .save_o     (save_o),
    .bp_cur_o   (bp_cur_o),
    .vec_valid_o(vec_valid_o),
    .vec_addr_o (vec_addr_o),
    .type_o     (cur_type)
  );

  assign type_o   = cur_type;
  assign int_en_o = gie_q;

  // R5
  irq_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && cur_kind == K_IRQ) |-> $past(boundary_i));

  // R4
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && cur_kind == K_IRQ) |-> $past(int_en_o));

  // R8
  ack_en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !int_en_o);

  // R9
  bp_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_o |-> (bp_cur_o == (type_o < TYPE_NMI)));

endmodule

// File: tb/prio_vec_intc_test.sv
module prio_vec_intc_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_i = '0;
  logic        nmi_i = 1'b0;
  logic        hw_fault_i = 1'b0;
  logic        sw_trap_i = 1'b0;
  logic        boundary_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        int_en_o, ack_o, save_o, bp_cur_o, vec_valid_o;
  logic [31:0] vec_addr_o;
  logic [7:0]  type_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] cur_base = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_vec_intc uut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .nmi_i(nmi_i),
    .hw_fault_i(hw_fault_i), .sw_trap_i(sw_trap_i), .boundary_i(boundary_i),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
    .int_en_o(int_en_o), .ack_o(ack_o), .save_o(save_o), .bp_cur_o(bp_cur_o),
    .vec_valid_o(vec_valid_o), .vec_addr_o(vec_addr_o), .type_o(type_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = data;
    @(negedge clk);
    cfg_we_i = 1'b0;
    if (sel == 2'd2) cur_base = data;
  endtask

  task automatic pulse_irq(input logic [7:0] v);
    irq_i = v;
    @(negedge clk);
    irq_i = '0;
  endtask

  task automatic strobe();
    boundary_i = 1'b1;
    @(negedge clk);
    boundary_i = 1'b0;
  endtask

  // Follows one acceptance through ack, save and vector cycles
  task automatic expect_take(input string req, input int ty, input bit bp);
    int waited = 0;
    while (!ack_o && waited < 8) begin
      @(negedge clk);
      waited++;
    end
    chk(ack_o, req, "acknowledge seen", 32'(ack_o), 1);
    if (!ack_o) return;
    chk(!int_en_o, "R8", "enable low at ack", 32'(int_en_o), 0);
    @(negedge clk);
    chk(save_o, "R8", "save follows ack", 32'(save_o), 1);
    chk(bp_cur_o == bp, "R9", "breakpoint select", 32'(bp_cur_o), 32'(bp));
    @(negedge clk);
    chk(vec_valid_o, "R8", "vector follows save", 32'(vec_valid_o), 1);
    chk(type_o == 8'(ty), req, "type number", 32'(type_o), 32'(ty));
    chk(vec_addr_o == cur_base + 32'(ty) * 4, "R10", "vector address",
        vec_addr_o, cur_base + 32'(ty) * 4);
    @(negedge clk);
  endtask

  task automatic expect_quiet(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (ack_o) seen++;
      @(negedge clk);
    end
    chk(seen == 0, req, "no acceptance", 32'(seen), 0);
  endtask

  task automatic t_reset();
    chk(!ack_o && !save_o && !vec_valid_o, "R1", "idle outputs",
        {29'd0, ack_o, save_o, vec_valid_o}, 0);
    chk(!int_en_o, "R1", "enable after reset", 32'(int_en_o), 0);
    cfg_write(2'd1, 32'd1);
    chk(int_en_o, "R12", "enable write", 32'(int_en_o), 1);
    pulse_irq(8'h01);
    strobe();
    expect_quiet("R1", 4);                // reset mask blocks all sources
    cfg_write(2'd0, 32'h0);
    strobe();
    expect_take("R2", 32, 1'b0);          // flag held through masking
    cfg_write(2'd1, 32'd1);
    strobe();
    expect_quiet("R2", 4);                // one pulse gives one acceptance
  endtask

  task automatic t_boundary_and_enable();
    pulse_irq(8'h08);
    expect_quiet("R5", 4);                // no strobe yet
    strobe();
    expect_take("R5", 35, 1'b0);
    pulse_irq(8'h04);
    strobe();
    expect_quiet("R4", 4);                // enable cleared by acceptance
    cfg_write(2'd1, 32'd1);
    strobe();
    expect_take("R4", 34, 1'b0);
  endtask

  task automatic t_mask();
    cfg_write(2'd0, 32'h20);
    cfg_write(2'd1, 32'd1);
    pulse_irq(8'h20);
    strobe();
    expect_quiet("R3", 4);
    cfg_write(2'd0, 32'h0);
    strobe();
    expect_take("R3", 37, 1'b0);
  endtask

  task automatic t_order();
    cfg_write(2'd1, 32'd1);
    pulse_irq(8'h12);
    strobe();
    expect_take("R7", 33, 1'b0);          // lower index first
    cfg_write(2'd1, 32'd1);
    strobe();
    expect_take("R7", 36, 1'b0);
    cfg_write(2'd1, 32'd1);
    pulse_irq(8'hC1);
    strobe();
    expect_take("R7", 38, 1'b0);          // DMA class above device
    cfg_write(2'd1, 32'd1);
    strobe();
    expect_take("R7", 39, 1'b0);
    cfg_write(2'd1, 32'd1);
    strobe();
    expect_take("R7", 32, 1'b0);
  endtask

  task automatic t_exceptions();
    hw_fault_i = 1'b1; sw_trap_i = 1'b1;
    @(negedge clk);
    hw_fault_i = 1'b0; sw_trap_i = 1'b0;
    expect_take("R6", 0, 1'b1);           // fault before trap, no strobe, enable off
    expect_take("R4", 1, 1'b1);
    expect_quiet("R2", 3);
  endtask

  task automatic t_nmi();
    nmi_i = 1'b1;
    @(negedge clk);
    expect_quiet("R5", 3);
    strobe();
    expect_take("R11", 2, 1'b0);
    strobe();
    strobe();
    expect_quiet("R11", 3);               // still high, no new edge
    nmi_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_same_cycle();
    cfg_write(2'd1, 32'd1);
    pulse_irq(8'h01);
    nmi_i = 1'b1; hw_fault_i = 1'b1;
    @(negedge clk);
    hw_fault_i = 1'b0;
    strobe();
    expect_take("R6", 2, 1'b0);           // NMI wins
    expect_take("R6", 0, 1'b1);           // then the fault
    nmi_i = 1'b0;
    strobe();
    expect_quiet("R6", 3);                // maskable waits for enable
    cfg_write(2'd1, 32'd1);
    strobe();
    expect_take("R6", 32, 1'b0);
  endtask

  task automatic t_race_and_base();
    cfg_write(2'd2, 32'h2000_0100);
    cfg_write(2'd1, 32'd1);
    pulse_irq(8'h10);
    boundary_i = 1'b1; cfg_we_i = 1'b1; cfg_sel_i = 2'd1; cfg_wdata_i = 32'd1;
    @(negedge clk);
    boundary_i = 1'b0; cfg_we_i = 1'b0;
    expect_take("R8", 36, 1'b0);          // enable write loses on the acceptance edge
    cfg_write(2'd1, 32'd1);
    pulse_irq(8'h80);
    strobe();
    expect_take("R10", 39, 1'b0);         // new table base
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_boundary_and_enable();
    t_mask();
    t_order();
    t_exceptions();
    t_nmi();
    t_same_cycle();
    t_race_and_base();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule